// File: doc/BRIEF.md
# Byte/Word Switchable Read-Only Memory Port

The block is a 2M-bit read-only memory whose organization is chosen at run time by a mode input. With the mode input high it serves 131,072 locations of 16 bits, addressed by a 17-bit address. With the mode input low it serves 262,144 locations of 8 bits: the topmost data lane no longer carries data and its pin supplies an extra address bit below the 17-bit address, which picks the low or the high half of the addressed word and steers that half onto the low byte lanes.

Reads are gated by an active-low chip select and two output enables. The active level of each output enable is fixed by a parameter, and the second enable can instead be set so that neither of its levels blocks the outputs. The data bus leaves the block as a 16-bit value with one drive enable per byte lane (a cleared enable stands for high impedance, and its lane then reads zero), a valid flag, and a status bit that separates standby from operating. Access delays are counted in clock cycles: one delay that restarts on every address, mode or chip-select change, and a shorter one that runs from the moment both output enables become active. Contents come from a closed-form function of the word address, so no storage is needed.

Top module: `bw_rom_port`

## Requirements
- R1: Word `a` (17 bits) holds `SEED ^ a[15:0] ^ {a[7:0], 8'h00} ^ {15'b0, a[16]}`, with SEED defaulting to 16'hC35A. With `wide_mode` = 1 a valid read drives `lane_en` = 2'b11 and `data_out` = that word of `addr`.
- R2: With `wide_mode` = 0 and `lsb_in` = 0 a valid read drives `lane_en` = 2'b01, `data_out[7:0]` = bits 7:0 of the word at `addr`, and `data_out[15:8]` = 0.
- R3: With `wide_mode` = 0 and `lsb_in` = 1 a valid read drives `lane_en` = 2'b01, `data_out[7:0]` = bits 15:8 of the word at `addr`, and `data_out[15:8]` = 0.
- R4: With `wide_mode` = 1, `lsb_in` has no effect: toggling it neither changes `data_out` nor drops `data_valid`.
- R5: While `chip_sel_n` = 1, `lane_en` = 0, `data_out` = 0, `data_valid` = 0 and `op_status` = 0, whatever the other inputs are.
- R6: While `chip_sel_n` = 0 and either output enable is at its inactive level, `lane_en` = 0, `data_out` = 0 and `data_valid` = 0, and `op_status` stays 1.
- R7: `OE_A_POL` and `OE_B_POL` choose active-low, active-high or (second enable) ignored; the defaults are `oe_a` active low and `oe_b` ignored, so with defaults both levels of `oe_b` let the outputs drive.
- R8: After a change of `addr`, `wide_mode`, `chip_sel_n`, or of `lsb_in` while `wide_mode` = 0, `data_valid` stays 0 until the `ADDR_LAT`-th rising clock edge after the change (default 3) and is 1 from then on while the inputs hold and both enables are active.
- R9: With the address settled, `data_valid` rises at the `OE_LAT`-th rising edge (default 1) after both output enables become active, and is 0 before it.
- R10: `op_status` equals the inverse of `chip_sel_n`; while `rst` is high and in the cycle after it falls, `data_valid` = 0 and `lane_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latency counters and the data register |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel_n | input | 1 | Chip select, active low; high means standby |
| oe_a | input | 1 | First output enable, level set by OE_A_POL |
| oe_b | input | 1 | Second output enable, level set by OE_B_POL or ignored |
| wide_mode | input | 1 | 1 = 16-bit word organization, 0 = 8-bit byte organization |
| addr | input | 17 | Word address |
| lsb_in | input | 1 | Extra low address bit used only in byte organization (shares the top data lane's pin) |
| data_out | output | 16 | Read data, zero on lanes that are not driven |
| lane_en | output | 2 | Drive enable per byte lane, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| data_valid | output | 1 | Read data has met every access delay |
| op_status | output | 1 | 0 in standby, 1 when operating |

## Verification
The assertions watch on every cycle that standby silences both lanes and clears the status, that an inactive first enable silences the lanes, that byte organization never drives the upper lane, and that a valid flag only appears after a cycle with chip select low and an unchanged address. Content values, the byte steering chosen by the extra address bit, the exact cycle at which each delay expires, the indifference of word mode to the extra bit, and the parameterized enable polarities can only be shown by the bench's scenarios, which predict each read from the content formula and compare it in the cycle the delay count places it.

// File: rtl/bw_rom_pkg.sv
package bw_rom_pkg;

    // Active level choice for an output-enable input.
    typedef enum logic [1:0] {
        OE_ACT_LOW  = 2'd0,
        OE_ACT_HIGH = 2'd1,
        OE_IGNORE   = 2'd2
    } oe_pol_e;

    // Organization selected by the mode input.
    typedef enum logic {
        ORG_BYTE = 1'b0,
        ORG_WORD = 1'b1
    } org_e;

    // Control part of the access key; any change restarts the access delay.
    typedef struct packed {
        logic cs_n;
        org_e org;
        logic half;
    } ctl_key_t;

    localparam int unsigned NUM_LANES = 2;
    localparam int unsigned NUM_OE    = 2;

    // Does an enable input at this level allow the outputs to drive?
    function automatic logic oe_pass(oe_pol_e pol, logic level);
        case (pol)
            OE_ACT_LOW:  return !level;
            OE_ACT_HIGH: return level;
            default:     return 1'b1;
        endcase
    endfunction

    // Lane enables for a valid read in the given organization.
    function automatic logic [NUM_LANES-1:0] lanes_for(org_e org);
        return (org == ORG_WORD) ? 2'b11 : 2'b01;
    endfunction

endpackage

// File: rtl/bw_oe_gate.sv
module bw_oe_gate
    import bw_rom_pkg::*;
#(
    parameter oe_pol_e POL = OE_ACT_LOW
) (
    input  logic level,
    output logic pass
);

    always_comb begin
        pass = oe_pass(POL, level);
    end

endmodule

// File: rtl/bw_settle_ctr.sv
module bw_settle_ctr #(
    parameter int unsigned LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic restart,
    output logic done
);

    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // The edge that sees a restart counts as the first elapsed cycle.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (cnt < LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt >= LIM);

endmodule

// File: rtl/bw_rom_content.sv
module bw_rom_content
    import bw_rom_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned LANE_W = 8,
    parameter logic [2*LANE_W-1:0] SEED = 'hC35A
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  org_e                  org,
    input  logic                  half,
    output logic [2*LANE_W-1:0]   data_q
);

    localparam int unsigned DATA_W = 2 * LANE_W;

    // Closed-form contents: seed, address, address shifted up a lane,
    // and the address bits above the word width folded into the bottom.
    function automatic logic [DATA_W-1:0] word_at(logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        lo = DATA_W'(a);
        hi = DATA_W'(a >> DATA_W);
        return SEED ^ lo ^ (lo << LANE_W) ^ hi;
    endfunction

    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] steered;

    assign word = word_at(addr);

    // Lane 0 takes the selected half in byte organization; lane 1 only
    // carries data in word organization.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        if (l == 0) begin : g_low
            always_comb begin
                if (org == ORG_BYTE && half)
                    steered[LANE_W-1:0] = word[DATA_W-1:LANE_W];
                else
                    steered[LANE_W-1:0] = word[LANE_W-1:0];
            end
        end else begin : g_high
            always_comb begin
                if (org == ORG_WORD)
                    steered[l*LANE_W +: LANE_W] = word[l*LANE_W +: LANE_W];
                else
                    steered[l*LANE_W +: LANE_W] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= steered;
    end

endmodule

// File: rtl/bw_rom_port.sv
module bw_rom_port
    import bw_rom_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned ADDR_LAT = 3,
    parameter int unsigned OE_LAT   = 1,
    parameter oe_pol_e     OE_A_POL = OE_ACT_LOW,
    parameter oe_pol_e     OE_B_POL = OE_IGNORE,
    parameter logic [2*LANE_W-1:0] SEED = 'hC35A
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chip_sel_n,
    input  logic                  oe_a,
    input  logic                  oe_b,
    input  logic                  wide_mode,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  lsb_in,
    output logic [2*LANE_W-1:0]   data_out,
    output logic [1:0]            lane_en,
    output logic                  data_valid,
    output logic                  op_status
);

    localparam int unsigned KEY_W = ADDR_W + $bits(ctl_key_t);
    localparam oe_pol_e POL_TAB [NUM_OE] = '{OE_A_POL, OE_B_POL};

    typedef struct packed {
        ctl_key_t              ctl;
        logic [ADDR_W-1:0]     addr;
    } access_key_t;

    // ---------------- output-enable decode ----------------
    logic [NUM_OE-1:0] oe_level;
    logic [NUM_OE-1:0] oe_ok;
    logic              oe_on;

    assign oe_level = {oe_b, oe_a};

    for (genvar g = 0; g < NUM_OE; g++) begin : g_oe
        bw_oe_gate #(.POL(POL_TAB[g])) u_gate (
            .level (oe_level[g]),
            .pass  (oe_ok[g])
        );
    end

    assign oe_on = &oe_ok;

    // ---------------- access key tracking ----------------
    org_e        org;
    access_key_t key_now;
    access_key_t key_q;
    logic        key_same;

    assign org = wide_mode ? ORG_WORD : ORG_BYTE;

    always_comb begin
        key_now.ctl.cs_n = chip_sel_n;
        key_now.ctl.org  = org;
        key_now.ctl.half = (org == ORG_BYTE) ? lsb_in : 1'b0;
        key_now.addr     = addr;
    end

    // Reset value has chip select high so the first enabled cycle restarts.
    always_ff @(posedge clk) begin
        if (rst) key_q <= access_key_t'({KEY_W{1'b1}});
        else     key_q <= key_now;
    end

    assign key_same = (key_now == key_q);

    // ---------------- latency counters ----------------
    logic acc_done;
    logic oe_done;

    bw_settle_ctr #(.LIMIT(ADDR_LAT)) u_acc_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (chip_sel_n),
        .restart (!key_same),
        .done    (acc_done)
    );

    bw_settle_ctr #(.LIMIT(OE_LAT)) u_oe_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (chip_sel_n || !oe_on),
        .restart (1'b0),
        .done    (oe_done)
    );

    // ---------------- data path ----------------
    logic [2*LANE_W-1:0] data_q;

    bw_rom_content #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .SEED   (SEED)
    ) u_content (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .org    (org),
        .half   (key_now.ctl.half),
        .data_q (data_q)
    );

    assign data_valid = !chip_sel_n && oe_on && key_same && acc_done && oe_done;
    assign lane_en    = data_valid ? lanes_for(org) : '0;
    assign op_status  = !chip_sel_n;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_drive
        assign data_out[l*LANE_W +: LANE_W] =
            lane_en[l] ? data_q[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/bw_rom_port_chk.sv
module bw_rom_port_chk
    import bw_rom_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned LANE_W   = 8,
    parameter oe_pol_e     OE_A_POL = OE_ACT_LOW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chip_sel_n,
    input  logic                  oe_a,
    input  logic                  wide_mode,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   data_out,
    input  logic [1:0]            lane_en,
    input  logic                  data_valid,
    input  logic                  op_status
);

    assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        chip_sel_n |-> (lane_en == '0 && data_out == '0 && !data_valid && !op_status));

    assert_operating_status_R10: assert property (@(posedge clk) disable iff (rst)
        !chip_sel_n |-> op_status);

    assert_oe_a_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        !oe_pass(OE_A_POL, oe_a) |-> (lane_en == '0 && data_out == '0));

    assert_byte_upper_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> (!lane_en[1] && data_out[2*LANE_W-1:LANE_W] == '0));

    assert_valid_after_select_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $past(!chip_sel_n));

    assert_valid_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $stable(addr));

endmodule

bind bw_rom_port bw_rom_port_chk #(
    .ADDR_W   (ADDR_W),
    .LANE_W   (LANE_W),
    .OE_A_POL (OE_A_POL)
) u_chk (.*);

// File: tb/test_bw_rom_port.sv
`timescale 1ns/1ps
module test_bw_rom_port;
    import bw_rom_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        chip_sel_n, oe_a, oe_b, wide_mode, lsb_in;
    logic [16:0] addr;
    logic [15:0] d0, d1;
    logic [1:0]  l0, l1;
    logic        v0, v1, s0, s1;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bw_rom_port i_bw_rom_port (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .oe_a(oe_a), .oe_b(oe_b),
        .wide_mode(wide_mode), .addr(addr), .lsb_in(lsb_in),
        .data_out(d0), .lane_en(l0), .data_valid(v0), .op_status(s0));

    // Second instance: first enable active high, second active low.
    bw_rom_port #(.OE_A_POL(OE_ACT_HIGH), .OE_B_POL(OE_ACT_LOW)) i_bw_rom_port_pol (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .oe_a(oe_a), .oe_b(oe_b),
        .wide_mode(wide_mode), .addr(addr), .lsb_in(lsb_in),
        .data_out(d1), .lane_en(l1), .data_valid(v1), .op_status(s1));

    function automatic logic [15:0] ref_word(logic [16:0] a);
        return 16'hC35A ^ a[15:0] ^ {a[7:0], 8'h00} ^ {15'b0, a[16]};
    endfunction

    typedef struct {
        int          due;
        string       tag;
        bit          inst;
        bit          v;
        logic [1:0]  ln;
        logic [15:0] d;
        bit          st;
    } exp_t;

    exp_t sb[$];

    task automatic push(int due, string tag, bit inst, bit v,
                        logic [1:0] ln, logic [15:0] d, bit st);
        exp_t e;
        e.due = due; e.tag = tag; e.inst = inst;
        e.v = v; e.ln = ln; e.d = d; e.st = st;
        sb.push_back(e);
    endtask

    task automatic exp_word(int due, string tag, bit inst, logic [16:0] a);
        push(due, tag, inst, 1'b1, 2'b11, ref_word(a), 1'b1);
    endtask

    task automatic exp_byte(int due, string tag, bit inst, logic [16:0] a, bit half);
        logic [15:0] w = ref_word(a);
        push(due, tag, inst, 1'b1, 2'b01, {8'h00, half ? w[15:8] : w[7:0]}, 1'b1);
    endtask

    task automatic exp_off(int due, string tag, bit inst, bit st);
        push(due, tag, inst, 1'b0, 2'b00, 16'h0000, st);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pops expectations as their cycle comes up.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            logic [15:0] ad;
            logic [1:0]  al;
            logic        av, ast;
            e = sb.pop_front();
            n_cmp++;
            ad  = e.inst ? d1 : d0;
            al  = e.inst ? l1 : l0;
            av  = e.inst ? v1 : v0;
            ast = e.inst ? s1 : s0;
            if (e.due < cyc) begin
                n_bad++;
                $display("FAIL %s: sample missed, due %0d actual cycle %0d expected on time",
                         e.tag, e.due, cyc);
            end else if (ad !== e.d || al !== e.ln || av !== e.v || ast !== e.st) begin
                n_bad++;
                $display("FAIL %s: inst %0d actual data=%h lanes=%b valid=%b status=%b expected data=%h lanes=%b valid=%b status=%b",
                         e.tag, e.inst, ad, al, av, ast, e.d, e.ln, e.v, e.st);
            end
        end
    end

    task automatic word_read(logic [16:0] a);
        int c;
        addr = a;
        c = cyc;
        exp_off(c + 2, "R8 address delay not met", 1'b0, 1'b1);
        exp_word(c + 3, "R1 word read", 1'b0, a);
        step(4);
    endtask

    initial begin
        int c;
        rst = 1'b1; chip_sel_n = 1'b0; oe_a = 1'b0; oe_b = 1'b0;
        wide_mode = 1'b1; addr = '0; lsb_in = 1'b0;
        step(1);
        exp_off(cyc, "R10 reset state", 1'b0, 1'b1);
        step(2);
        rst = 1'b0;
        c = cyc;
        exp_off(c + 1, "R10 first cycle after reset", 1'b0, 1'b1);
        exp_off(c + 2, "R8 delay after reset", 1'b0, 1'b1);
        exp_word(c + 3, "R1 word read at 0", 1'b0, 17'h0);
        step(4);

        word_read(17'h1_2345);
        word_read(17'h1_FFFF);
        word_read(17'h0_00FF);
        word_read(17'h0_AAAA);

        // R4: extra address bit ignored in word organization
        lsb_in = 1'b1;
        exp_word(cyc, "R4 lsb ignored in word mode", 1'b0, 17'h0_AAAA);
        step(2);
        lsb_in = 1'b0;
        exp_word(cyc, "R4 lsb back low in word mode", 1'b0, 17'h0_AAAA);
        step(1);

        // Byte organization
        wide_mode = 1'b0; lsb_in = 1'b0; addr = 17'h1_3C81;
        c = cyc;
        exp_off(c + 2, "R8 mode change delay", 1'b0, 1'b1);
        exp_byte(c + 3, "R2 byte low half", 1'b0, 17'h1_3C81, 1'b0);
        step(4);
        lsb_in = 1'b1;
        c = cyc;
        exp_off(c + 2, "R8 extra address bit restarts delay", 1'b0, 1'b1);
        exp_byte(c + 3, "R3 byte high half", 1'b0, 17'h1_3C81, 1'b1);
        step(4);
        addr = 17'h0_5E07;
        c = cyc;
        exp_byte(c + 3, "R3 byte high half second address", 1'b0, 17'h0_5E07, 1'b1);
        step(4);
        lsb_in = 1'b0;
        c = cyc;
        exp_byte(c + 3, "R2 byte low half second address", 1'b0, 17'h0_5E07, 1'b0);
        step(4);

        // Back to word organization, then output-enable timing
        wide_mode = 1'b1; addr = 17'h0_1234;
        c = cyc;
        exp_word(c + 3, "R1 word read after byte mode", 1'b0, 17'h0_1234);
        step(4);
        oe_a = 1'b1;
        exp_off(cyc, "R6 first enable inactive", 1'b0, 1'b1);
        step(3);
        exp_off(cyc, "R6 first enable still inactive", 1'b0, 1'b1);
        oe_a = 1'b0;
        c = cyc;
        exp_off(c, "R9 enable delay not met", 1'b0, 1'b1);
        exp_word(c + 1, "R9 valid after enable delay", 1'b0, 17'h0_1234);
        step(2);

        // R7: second enable ignored by default
        oe_b = 1'b1;
        exp_word(cyc, "R7 second enable high ignored", 1'b0, 17'h0_1234);
        step(1);
        oe_b = 1'b0;
        exp_word(cyc, "R7 second enable low ignored", 1'b0, 17'h0_1234);
        exp_off(cyc, "R7 active-high first enable blocks", 1'b1, 1'b1);
        step(1);

        // R7 / R6 on the instance with swapped polarities
        oe_a = 1'b1; oe_b = 1'b0;
        c = cyc;
        exp_off(c, "R6 default instance blocked by high first enable", 1'b0, 1'b1);
        exp_word(c + 1, "R7 swapped polarities allow drive", 1'b1, 17'h0_1234);
        step(2);
        oe_b = 1'b1;
        exp_off(cyc, "R6 active-low second enable inactive", 1'b1, 1'b1);
        step(1);
        oe_a = 1'b0; oe_b = 1'b0;
        c = cyc;
        exp_word(c + 1, "R9 default instance re-enabled", 1'b0, 17'h0_1234);
        step(2);

        // R5: standby
        chip_sel_n = 1'b1;
        exp_off(cyc, "R5 standby", 1'b0, 1'b0);
        exp_off(cyc, "R5 standby second instance", 1'b1, 1'b0);
        step(1);
        addr = 17'h1_0F0F; oe_a = 1'b1; wide_mode = 1'b0;
        exp_off(cyc, "R5 standby with other inputs moving", 1'b0, 1'b0);
        step(2);
        oe_a = 1'b0; wide_mode = 1'b1;
        exp_off(cyc, "R5 standby with enables active", 1'b0, 1'b0);
        step(1);
        chip_sel_n = 1'b0;
        c = cyc;
        exp_off(c, "R10 operating while delay runs", 1'b0, 1'b1);
        exp_off(c + 2, "R8 chip select delay", 1'b0, 1'b1);
        exp_word(c + 3, "R8 valid after chip select delay", 1'b0, 17'h1_0F0F);
        step(5);

        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_bad++;
            $display("FAIL %s: never sampled, actual none expected due %0d", e.tag, e.due);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule